// File: doc/BRIEF.md
# Level-Masked Edge Interrupt Controller

This block gathers sixteen edge-signalled interrupt sources and one privileged external line. It turns them into a single encoded interrupt number for a processor. Each source has a 3-bit priority that software programs. A rising edge on a source forwards that source's vector only when its priority is strictly above one global threshold held in a mask-level register. A source whose priority does not pass still records its event in an active-low status register. The privileged line bypasses the compare and always produces vector 32. When any input falls, the controller reports vector 0, which tells the processor that the interrupt has gone away.

Software reaches the status, threshold and priority registers through a small word-addressed bus. The bus has byte-lane write strobes and a combinational read path. Source numbering follows the bit index of `src_irq`:
- bits 0 to 6 are external lines 1 to 7;
- bits 7 to 10 are DMA channels 3, 2, 1 and 0;
- bits 11 and 12 are serial ports 0 and 1;
- bits 13 to 15 are timers 0 to 2.

A synchronous `soft_rst` input returns the register bank to its power-on values.

Top module: `irq_level_ctrl`

## Requirements
- R1: After `rst_n` is released, `vec_out` is 0, `vec_strobe` is 0, status reads 0x0000FFFF, and the threshold and all priority words read 0.
- R2: The word index `bus_word` selects registers as follows: 0 is status, 1 is threshold, and 4, 5, 6 and 7 hold the priorities of sources 0–3, 4–7, 8–11 and 12–15. Reads of indices 2 and 3 return 0, and writes to them change no register.
- R3: A write updates only the bytes whose `bus_be` bit is set; lane i covers data bits [8i+7:8i].
- R4: A rising edge on source s clears status bit s to 0, whether or not the priority compare passes. Writing 1 sets a bit again. An edge in the same cycle as a status write overrides the written value for that bit.
- R5: The priority of source s is bits [2:0] of byte (s mod 4) in priority word s/4. Bits [7:3] of each byte are stored but take no part in the compare.
- R6: On a rising edge of source s, if its priority is strictly greater than the whole 32-bit threshold, then in the next cycle `vec_out` is 16+s and `vec_strobe` is 1. Otherwise `vec_out` keeps its value and no strobe occurs.
- R7: A rising edge on `spec_irq` loads vector 32 in the next cycle with a strobe. No priority applies to it, and it wins over any source edge in the same cycle.
- R8: When several sources pass in the same cycle, the lowest-numbered one sets the vector. A passing rise wins over a same-cycle fall.
- R9: A falling edge on any source or on `spec_irq`, with no passing rise in that cycle, loads vector 0 with a strobe.
- R10: `soft_rst` restores the R1 register values in the next cycle and wins over a bus write in the same cycle. It leaves `vec_out` unchanged.
- R11: `vec_strobe` is high only in the cycle after `vec_out` is loaded. `vec_out` does not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous register-bank reset |
| src_irq | input | 16 | Interrupt source levels, bit index = source number |
| spec_irq | input | 1 | Privileged external interrupt line |
| bus_word | input | 3 | Word index within the register window |
| bus_wr | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word` (combinational) |
| vec_out | output | 6 | Encoded interrupt number (0, 16..31, 32) |
| vec_strobe | output | 1 | One-cycle pulse when `vec_out` is loaded |

## Verification
The embedded assertions check the following on every cycle:
- every edge clears its status bit;
- the privileged line forces vector 32;
- soft reset restores the bank;
- `vec_out` holds whenever no strobe is present;
- no strobe appears without a qualifying edge;
- every strobed vector lies in the legal set.

Only the bench scenarios can show the rest. That covers the exact vector numbers for a given priority programming, and the lowest-index choice among simultaneous passes. It also covers the equal-priority and wide-threshold boundaries, the priority bits that are ignored, the byte-lane merging, the unmapped window slots, and the ordering between an edge and a same-cycle status write.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
   localparam int WORD_W      = 32;
   localparam int BYTE_W      = 8;
   localparam int LANES       = WORD_W / BYTE_W;
   localparam int WADDR_W     = 3;
   localparam int STATUS_WORD = 0;
   localparam int THRESH_WORD = 1;
   localparam int PRIO_WORD0  = 4;

   function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  be);
      logic [WORD_W-1:0] res;
      res = old_w;
      for (int i = 0; i < LANES; i++)
         if (be[i]) res[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
      return res;
   endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig;

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
   import irq_lvl_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int PRIO_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      soft_rst,
   input  logic [WADDR_W-1:0]        bus_word,
   input  logic                      bus_wr,
   input  logic [LANES-1:0]          bus_be,
   input  logic [WORD_W-1:0]         bus_wdata,
   output logic [WORD_W-1:0]         bus_rdata,
   input  logic [NUM_SRC-1:0]        src_rise,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic [WORD_W-1:0]         thresh
);
   localparam int SLOTS   = LANES;
   localparam int NUM_LVL = NUM_SRC / SLOTS;
   localparam logic [WORD_W-1:0] STATUS_INIT = WORD_W'((64'd1 << NUM_SRC) - 64'd1);

   initial begin
      assert_param_src_multiple: assert (NUM_SRC % SLOTS == 0 && NUM_SRC > 0)
         else $error("NUM_SRC must be a positive multiple of %0d", SLOTS);
      assert_param_src_window: assert (PRIO_WORD0 + NUM_LVL <= (1 << WADDR_W))
         else $error("priority words exceed the register window");
      assert_param_prio_fits: assert (PRIO_W > 0 && PRIO_W <= BYTE_W)
         else $error("PRIO_W must fit a byte slot");
   end

   logic [WORD_W-1:0] status_q, thresh_q;
   logic [WORD_W-1:0] lvl_q [NUM_LVL];
   logic [WORD_W-1:0] status_d, rise_w;

   assign rise_w = WORD_W'(src_rise);

   always_comb begin
      status_d = status_q;
      if (bus_wr && bus_word == WADDR_W'(STATUS_WORD))
         status_d = lane_merge(status_q, bus_wdata, bus_be);
      status_d = status_d & ~rise_w;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         status_q <= STATUS_INIT;
         thresh_q <= '0;
      end else if (soft_rst) begin
         status_q <= STATUS_INIT;
         thresh_q <= '0;
      end else begin
         status_q <= status_d;
         if (bus_wr && bus_word == WADDR_W'(THRESH_WORD))
            thresh_q <= lane_merge(thresh_q, bus_wdata, bus_be);
      end

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        lvl_q[k] <= '0;
         else if (soft_rst) lvl_q[k] <= '0;
         else if (bus_wr && bus_word == WADDR_W'(PRIO_WORD0 + k))
            lvl_q[k] <= lane_merge(lvl_q[k], bus_wdata, bus_be);
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
      assign prio_flat[s*PRIO_W +: PRIO_W] = lvl_q[s/SLOTS][(s%SLOTS)*BYTE_W +: PRIO_W];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_word == WADDR_W'(STATUS_WORD)) bus_rdata = status_q;
      if (bus_word == WADDR_W'(THRESH_WORD)) bus_rdata = thresh_q;
      for (int k = 0; k < NUM_LVL; k++)
         if (bus_word == WADDR_W'(PRIO_WORD0 + k)) bus_rdata = lvl_q[k];
   end

   assign thresh = thresh_q;

   assert_edge_clears_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rise != '0 && !soft_rst) |=> ((status_q & WORD_W'($past(src_rise))) == '0));

   assert_soft_reset_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (status_q == STATUS_INIT && thresh_q == '0));
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
   parameter int NUM_SRC     = 16,
   parameter int PRIO_W      = 3,
   parameter int VEC_W       = 6,
   parameter int VEC_BASE    = 16,
   parameter int SPECIAL_VEC = 32,
   parameter int CMP_W       = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_rise,
   input  logic [NUM_SRC-1:0]        src_fall,
   input  logic                      spec_rise,
   input  logic                      spec_fall,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic [CMP_W-1:0]          thresh,
   output logic [VEC_W-1:0]          vec_out,
   output logic                      vec_strobe
);
   localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   initial begin
      assert_param_vec_span: assert (VEC_BASE + NUM_SRC <= (1 << VEC_W))
         else $error("source vectors exceed VEC_W");
      assert_param_special: assert (SPECIAL_VEC > 0 && SPECIAL_VEC < (1 << VEC_W) &&
                                    (SPECIAL_VEC < VEC_BASE || SPECIAL_VEC >= VEC_BASE + NUM_SRC))
         else $error("SPECIAL_VEC collides or does not fit");
      assert_param_base: assert (VEC_BASE > 0) else $error("VEC_BASE must be nonzero");
   end

   logic [NUM_SRC-1:0] pass;
   logic [SIDX_W-1:0]  win;
   logic               hit, load;
   logic [VEC_W-1:0]   vec_d;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
      assign pass[s] = src_rise[s] &&
                       (CMP_W'(prio_flat[s*PRIO_W +: PRIO_W]) > thresh);
   end

   always_comb begin
      hit = 1'b0;
      win = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--)
         if (pass[s]) begin
            hit = 1'b1;
            win = SIDX_W'(s);
         end
   end

   always_comb begin
      load  = 1'b1;
      vec_d = '0;
      if (spec_rise)                      vec_d = VEC_W'(SPECIAL_VEC);
      else if (hit)                       vec_d = VEC_W'(VEC_BASE) + VEC_W'(win);
      else if (spec_fall || |src_fall)    vec_d = '0;
      else                                load = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         vec_out    <= '0;
         vec_strobe <= 1'b0;
      end else begin
         vec_strobe <= load;
         if (load) vec_out <= vec_d;
      end

   assert_special_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      spec_rise |=> (vec_strobe && vec_out == VEC_W'(SPECIAL_VEC)));

   assert_quiet_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!spec_rise && !spec_fall && pass == '0 && src_fall == '0) |=> !vec_strobe);

   assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_strobe |-> (vec_out == $past(vec_out)));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
   import irq_lvl_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int PRIO_W      = 3,
   parameter int VEC_W       = 6,
   parameter int VEC_BASE    = 16,
   parameter int SPECIAL_VEC = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic [NUM_SRC-1:0]   src_irq,
   input  logic                 spec_irq,
   input  logic [WADDR_W-1:0]   bus_word,
   input  logic                 bus_wr,
   input  logic [LANES-1:0]     bus_be,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 vec_strobe
);
   localparam int EDGE_W = NUM_SRC + 1;

   logic [EDGE_W-1:0]         rise_all, fall_all;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [WORD_W-1:0]         thresh;

   irq_edge_detect #(.W(EDGE_W)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  ({spec_irq, src_irq}),
      .rise (rise_all),
      .fall (fall_all)
   );

   irq_reg_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .bus_word (bus_word),
      .bus_wr   (bus_wr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .src_rise (rise_all[NUM_SRC-1:0]),
      .prio_flat(prio_flat),
      .thresh   (thresh)
   );

   irq_vector_sel #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
      .VEC_BASE(VEC_BASE), .SPECIAL_VEC(SPECIAL_VEC), .CMP_W(WORD_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_rise  (rise_all[NUM_SRC-1:0]),
      .src_fall  (fall_all[NUM_SRC-1:0]),
      .spec_rise (rise_all[NUM_SRC]),
      .spec_fall (fall_all[NUM_SRC]),
      .prio_flat (prio_flat),
      .thresh    (thresh),
      .vec_out   (vec_out),
      .vec_strobe(vec_strobe)
   );

   assert_vector_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_strobe |-> (vec_out == '0 || vec_out == VEC_W'(SPECIAL_VEC) ||
                      (vec_out >= VEC_W'(VEC_BASE) && vec_out < VEC_W'(VEC_BASE + NUM_SRC))));
endmodule

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [15:0] src_irq = '0;
   logic        spec_irq = 1'b0;
   logic [2:0]  bus_word = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  vec_out;
   logic        vec_strobe;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_level_ctrl uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .src_irq(src_irq),
      .spec_irq(spec_irq), .bus_word(bus_word), .bus_wr(bus_wr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vec_out(vec_out),
      .vec_strobe(vec_strobe)
   );

   // entry: {src[15:0], spec, vec[5:0], strobe}; thresholds/priorities set before walk
   localparam logic [23:0] TBL [15] = '{
      {16'h0001, 1'b0, 6'd16, 1'b1},   // R6 s0 prio5 > 2
      {16'h0001, 1'b0, 6'd16, 1'b0},   // R11 hold
      {16'h0000, 1'b0, 6'd0,  1'b1},   // R9 fall
      {16'h0002, 1'b0, 6'd0,  1'b0},   // R6 s1 prio2 == thresh, masked
      {16'h0000, 1'b0, 6'd0,  1'b1},   // R9 fall of masked source
      {16'h0A00, 1'b0, 6'd25, 1'b1},   // R8 s9 passes, s11 masked
      {16'h0A00, 1'b0, 6'd25, 1'b0},   // R11 hold
      {16'hA010, 1'b0, 6'd20, 1'b1},   // R8 lowest of s4,s13,s15, rise beats fall
      {16'hA010, 1'b1, 6'd32, 1'b1},   // R7 special line
      {16'hA01C, 1'b1, 6'd18, 1'b1},   // R8 s2 passes, s3 masked
      {16'h0000, 1'b0, 6'd0,  1'b1},   // R9 falls
      {16'h8000, 1'b0, 6'd31, 1'b1},   // R6 s15
      {16'h8400, 1'b0, 6'd31, 1'b0},   // R6 s10 prio1 masked
      {16'h0000, 1'b1, 6'd32, 1'b1},   // R7 special beats falls
      {16'h0000, 1'b0, 6'd0,  1'b1}    // R9 special fall
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] w, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_check(input string tag, input logic [2:0] w, input logic [31:0] exp);
      @(negedge clk);
      bus_word = w;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic drive_src(input logic [15:0] s, input logic sp);
      @(negedge clk);
      src_irq = s; spec_irq = sp;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 vec_out", 32'(vec_out), 32'd0);
      chk("R1 strobe", 32'(vec_strobe), 32'd0);
      bus_check("R1 status", 3'd0, 32'h0000FFFF);
      bus_check("R1 thresh", 3'd1, 32'h0);
      for (int k = 4; k < 8; k++) bus_check("R1 prio word", 3'(k), 32'h0);

      // program priorities (R5: s0 byte 0xF5 -> prio 5) and threshold 2
      bus_write(3'd4, 4'hF, 32'h010702F5);
      bus_write(3'd5, 4'hF, 32'h04000603);
      bus_write(3'd6, 4'hF, 32'h02010707);
      bus_write(3'd7, 4'hF, 32'h03060504);
      bus_write(3'd1, 4'hF, 32'h00000002);
      bus_check("R2 prio word 4", 3'd4, 32'h010702F5);
      bus_check("R2 prio word 7", 3'd7, 32'h03060504);

      for (int i = 0; i < 15; i++) begin
         drive_src(TBL[i][23:8], TBL[i][7]);
         chk($sformatf("R6/R7/R8/R9/R11 table step %0d vec", i), 32'(vec_out), 32'(TBL[i][6:1]));
         chk($sformatf("R11 table step %0d strobe", i), 32'(vec_strobe), 32'(TBL[i][0]));
      end

      // R4 every rising source cleared its bit, masked ones included
      bus_check("R4 status after walk", 3'd0, 32'h000051E0);
      bus_write(3'd0, 4'h3, 32'h0000FFFF);
      bus_check("R4 write one resets flags", 3'd0, 32'h0000FFFF);
      // R3 byte lanes
      bus_write(3'd0, 4'h1, 32'hFFFFFF00);
      bus_check("R3 lane0 only", 3'd0, 32'h0000FF00);
      bus_write(3'd0, 4'h1, 32'h000000FF);
      // R2 unmapped
      bus_write(3'd2, 4'hF, 32'hFFFFFFFF);
      bus_write(3'd3, 4'hF, 32'hFFFFFFFF);
      bus_check("R2 unmapped read", 3'd2, 32'h0);
      bus_check("R2 unmapped read 3", 3'd3, 32'h0);
      bus_check("R2 status untouched", 3'd0, 32'h0000FFFF);
      bus_check("R2 thresh untouched", 3'd1, 32'h2);
      bus_check("R2 prio untouched", 3'd5, 32'h04000603);

      // R3/R6 wide threshold blocks prio 7
      bus_write(3'd1, 4'h2, 32'h00000100);
      bus_check("R3 thresh lane1", 3'd1, 32'h00000102);
      drive_src(16'h0004, 1'b0);
      chk("R6 wide threshold vec", 32'(vec_out), 32'd0);
      chk("R6 wide threshold strobe", 32'(vec_strobe), 32'd0);
      drive_src(16'h0000, 1'b0);
      chk("R9 fall strobe", 32'(vec_strobe), 32'd1);

      // R5 upper slot bits ignored: s0 prio5 vs threshold 5
      bus_write(3'd1, 4'hF, 32'h5);
      drive_src(16'h0001, 1'b0);
      chk("R5 prio5 not above 5 vec", 32'(vec_out), 32'd0);
      chk("R5 prio5 not above 5 strobe", 32'(vec_strobe), 32'd0);
      drive_src(16'h0101, 1'b0);
      chk("R5 s8 prio7 passes", 32'(vec_out), 32'd24);
      drive_src(16'h0000, 1'b0);
      chk("R9 back to zero", 32'(vec_out), 32'd0);

      // R4 edge beats same-cycle status write
      @(negedge clk);
      bus_word = 3'd0; bus_be = 4'hF; bus_wdata = 32'h0000FFFF; bus_wr = 1'b1;
      src_irq = 16'h0020;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R6 s5 prio6 vec", 32'(vec_out), 32'd21);
      bus_check("R4 edge beats write", 3'd0, 32'h0000FFDF);

      // R10 soft reset beats bus write, vec_out held
      @(negedge clk);
      soft_rst = 1'b1;
      bus_word = 3'd1; bus_be = 4'hF; bus_wdata = 32'h7; bus_wr = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0; bus_wr = 1'b0;
      chk("R10 vec held", 32'(vec_out), 32'd21);
      bus_check("R10 status", 3'd0, 32'h0000FFFF);
      bus_check("R10 thresh", 3'd1, 32'h0);
      bus_check("R10 prio word", 3'd6, 32'h0);
      drive_src(16'h0000, 1'b0);
      chk("R9 after soft reset", 32'(vec_out), 32'd0);
      // R6 equal priority 0 vs threshold 0 does not pass
      drive_src(16'h0001, 1'b0);
      chk("R6 tie at zero strobe", 32'(vec_strobe), 32'd0);
      bus_check("R4 masked still flags", 3'd0, 32'h0000FFFE);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule